// File: doc/BRIEF.md
# Warm Reset Sequencer with Cause Log

This block controls the warm reset of a processor subsystem. It also keeps a sticky log of every event that caused a reset. A warm reset starts when any warm source shows a rising edge: the external pin, an FPGA warm request, software, or one of four watchdogs. Before any reset line moves, the block runs each handshake that is enabled, in a fixed order: SDRAM self-refresh entry, FPGA manager quiesce, scan manager quiesce, FPGA soft-logic notice, and trace bus stall. Each handshake waits for its acknowledge or for a timeout. A timeout is logged and the sequence moves on.

After the handshakes, the block asserts the clock-domain reset and the system reset. It also drives the external reset pin low for a programmed number of cycles. It then releases the clock-domain reset first and holds the system reset for a programmed delay. Any cold-reset source overrides everything: it aborts a sequence in progress and holds all resets for as long as the source stays high.

Software reads the log on `cause` and clears any subset of it by writing a mask.

Top module: `warm_rst_seq`

## Requirements
- R1: While `rst_n` is low, `clk_rst` and `sys_rst` are 1, `pin_rst_n` is 0, `hs_req` is 0 and `cause` is 0. After `rst_n` rises, the block passes through the release phase of R8 and then goes idle.
- R2: Each cycle that a source is high, its `cause` bit is set, and the bit stays set until it is cleared. The bit positions are:
  - `cold_req[4:0]` set bits 4:0.
  - `warm_req[2:0]` (pin, FPGA, software) set bits 10:8.
  - `warm_req[6:3]` (watchdogs 0 to 3) set bits 15:12.
  - `dbg_req[1:0]` set bits 19:18.
  - All other bits stay 0.
- R3: A handshake timeout on partner k (0 SDRAM, 1 FPGA manager, 2 scan manager, 3 FPGA, 4 trace stall) sets `cause` bit 24+k.
- R4: A cycle with `clr_we` high clears the `cause` bits that are set in `clr_mask`. A source that is active in the same cycle wins over the clear.
- R5: In the handshake phase, partners are visited in the order 0 to 4. At most one `hs_req` bit is high at a time. A partner whose `cfg_hs_en` bit is 0 is skipped in one cycle, and its request is never raised.
- R6: An enabled request stays high until `hs_ack` for that partner is sampled high. If no acknowledge arrives, the request stays high for exactly HS_TIMEOUT cycles, and then the sequence moves to the next partner.
- R7: After the handshakes, `clk_rst` and `sys_rst` are held for max(`cfg_pin_len`,1) cycles. During those cycles `pin_rst_n` is 0 only if `cfg_pin_len` is nonzero; a value of 0 never drives the pin.
- R8: `clk_rst` is released first. `sys_rst` then stays high for max(`cfg_rel_dly`, MIN_DLY = 17) more cycles. `clk_rst` is never high while `sys_rst` is low.
- R9: A sequence starts only on a rising edge of a warm source while the block is idle. A warm request that rises during a sequence is logged but does not start a new one.
- R10: One cycle after any `cold_req` bit is high, all three resets are asserted and `hs_req` is 0. When the cold source falls, the block goes to the release phase of R8.
- R11: `busy` is 1 from the cycle after a sequence starts until it returns to idle, and it is 1 whenever any reset or request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| cold_req | input | 5 | Cold-reset sources |
| warm_req | input | 7 | Warm sources: pin, FPGA, software, watchdogs 0-3 |
| dbg_req | input | 2 | Debug reset sources, logged only |
| cfg_rel_dly | input | 8 | System reset hold after the clock-domain release |
| cfg_pin_len | input | 20 | External pin pulse length in cycles |
| cfg_hs_en | input | 5 | Per-partner handshake enables |
| clr_we | input | 1 | Clear strobe for the cause log |
| clr_mask | input | 32 | Bits to clear |
| hs_ack | input | 5 | Handshake acknowledges |
| hs_req | output | 5 | Handshake requests |
| clk_rst | output | 1 | Clock-domain reset |
| sys_rst | output | 1 | Other hardware resets |
| pin_rst_n | output | 1 | External reset pin, active low |
| busy | output | 1 | A sequence or cold hold is in progress |
| cause | output | 32 | Sticky cause log |

## Verification
The hardest situation to reach is a cold source that arrives in the middle of a handshake, while a partner's request is still pending. The bench starts a sequence with every partner enabled and no acknowledges. It then raises a cold source a few cycles into the first handshake. It checks that the request drops and that all resets assert on the next cycle.

A second hard case is a watchdog edge that arrives during a running sequence. The bench checks that the edge is logged and that no second sequence follows. A behavioural reference model is compared with every output on every clock. It covers the timeout count, the clamp on the release delay and a pin length of zero.

// File: rtl/warm_rst_seq.sv
module warm_rst_seq #(
  parameter int HS_TIMEOUT = 65535,
  parameter int DLY_W      = 8,
  parameter int PIN_W      = 20,
  parameter int MIN_DLY    = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        cold_req,
  input  logic [6:0]        warm_req,
  input  logic [1:0]        dbg_req,
  input  logic [DLY_W-1:0]  cfg_rel_dly,
  input  logic [PIN_W-1:0]  cfg_pin_len,
  input  logic [4:0]        cfg_hs_en,
  input  logic              clr_we,
  input  logic [31:0]       clr_mask,
  input  logic [4:0]        hs_ack,
  output logic [4:0]        hs_req,
  output logic              clk_rst,
  output logic              sys_rst,
  output logic              pin_rst_n,
  output logic              busy,
  output logic [31:0]       cause
);

  localparam int TW = $clog2(HS_TIMEOUT + 1);
  localparam int CW = ((PIN_W > DLY_W) ? PIN_W : DLY_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_HS, S_RST, S_REL, S_COLD} st_t;

  st_t             st;
  logic [2:0]      idx;
  logic [TW-1:0]   tmo;
  logic [CW-1:0]   cnt;
  logic [6:0]      warm_q;

  logic [7:0]      en_ext, ack_ext;
  logic            hs_on, hs_tmo, hs_done, rst_last, rel_last;
  logic [CW-1:0]   dly_eff;
  logic [4:0]      tmo_vec;
  logic [31:0]     ev;

  assign en_ext   = {3'b000, cfg_hs_en};
  assign ack_ext  = {3'b000, hs_ack};
  assign hs_on    = en_ext[idx];
  assign hs_tmo   = (st == S_HS) && hs_on && !ack_ext[idx] && (tmo == TW'(HS_TIMEOUT - 1));
  assign hs_done  = (st == S_HS) && (!hs_on || ack_ext[idx] || hs_tmo);
  assign tmo_vec  = (5'b00001 << idx) & {5{hs_tmo}};

  assign dly_eff  = (cfg_rel_dly < DLY_W'(MIN_DLY)) ? CW'(MIN_DLY) : CW'(cfg_rel_dly);
  assign rst_last = (cnt + 1'b1) >= CW'(cfg_pin_len);
  assign rel_last = (cnt + 1'b1) >= dly_eff;

  assign ev = {3'b000, tmo_vec, 4'b0000, dbg_req, 2'b00, warm_req[6:3], 1'b0,
               warm_req[2:0], 3'b000, cold_req};

  assign hs_req    = (st == S_HS) ? (cfg_hs_en & (5'b00001 << idx)) : 5'b00000;
  assign clk_rst   = (st == S_RST) || (st == S_COLD);
  assign sys_rst   = clk_rst || (st == S_REL);
  assign pin_rst_n = !(((st == S_RST) && (cfg_pin_len != '0)) || (st == S_COLD));
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_COLD;
      idx    <= '0;
      tmo    <= '0;
      cnt    <= '0;
      warm_q <= '0;
      cause  <= '0;
    end else begin
      warm_q <= warm_req;
      cause  <= (cause & ~(clr_we ? clr_mask : 32'h0)) | ev;
      if (|cold_req) begin
        st  <= S_COLD;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE: if (|(warm_req & ~warm_q)) begin
            st  <= S_HS;
            idx <= '0;
            tmo <= '0;
          end
          S_HS: if (hs_done) begin
            tmo <= '0;
            if (idx == 3'd4) begin
              st  <= S_RST;
              cnt <= '0;
            end else begin
              idx <= idx + 3'd1;
            end
          end else begin
            tmo <= tmo + 1'b1;
          end
          S_RST: if (rst_last) begin
            st  <= S_REL;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
          S_REL: if (rel_last) st <= S_IDLE;
                 else cnt <= cnt + 1'b1;
          S_COLD: begin
            st  <= S_REL;
            cnt <= '0;
          end
          default: st <= S_COLD;
        endcase
      end
    end
  end

endmodule

// File: rtl/warm_rst_seq_sva.sv
module warm_rst_seq_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  cold_req,
  input logic        clr_we,
  input logic [4:0]  hs_req,
  input logic        clk_rst,
  input logic        sys_rst,
  input logic        pin_rst_n,
  input logic        busy,
  input logic [31:0] cause
);

  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rst |-> sys_rst); // R8

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hs_req)); // R5

  AST_NO_REQ_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (hs_req == 5'b00000)); // R5

  AST_COLD_HOLDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (|cold_req) |=> (clk_rst && sys_rst && !pin_rst_n && hs_req == 5'b00000)); // R10

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((cause & $past(cause)) == $past(cause))); // R2

  AST_PIN_WITHIN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_rst_n |-> clk_rst); // R7

  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst || hs_req != 5'b00000) |-> busy); // R11

endmodule

bind warm_rst_seq warm_rst_seq_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cold_req(cold_req), .clr_we(clr_we),
  .hs_req(hs_req), .clk_rst(clk_rst), .sys_rst(sys_rst),
  .pin_rst_n(pin_rst_n), .busy(busy), .cause(cause)
);

// File: tb/warm_rst_seq_tb_top.sv
`timescale 1ns/1ps
module warm_rst_seq_tb_top;
  localparam int TMO = 12;

  logic clk = 0, rst_n = 0;
  logic [4:0]  cold_req = 0;
  logic [6:0]  warm_req = 0;
  logic [1:0]  dbg_req = 0;
  logic [7:0]  cfg_rel_dly = 8'd20;
  logic [19:0] cfg_pin_len = 20'd5;
  logic [4:0]  cfg_hs_en = 5'b11111;
  logic        clr_we = 0;
  logic [31:0] clr_mask = 0;
  logic [4:0]  hs_ack = 0;
  logic [4:0]  hs_req;
  logic        clk_rst, sys_rst, pin_rst_n, busy;
  logic [31:0] cause;

  int errors = 0, checks = 0;
  logic [4:0] ack_ok = 5'b11111;
  int wc [5];
  int n_pin = 0, n_rel = 0, n_req0 = 0;
  int order_q[$];
  logic [4:0] last_req = 0;

  always #10 clk = ~clk;

  warm_rst_seq #(.HS_TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cold_req(cold_req), .warm_req(warm_req),
    .dbg_req(dbg_req), .cfg_rel_dly(cfg_rel_dly), .cfg_pin_len(cfg_pin_len),
    .cfg_hs_en(cfg_hs_en), .clr_we(clr_we), .clr_mask(clr_mask),
    .hs_ack(hs_ack), .hs_req(hs_req), .clk_rst(clk_rst), .sys_rst(sys_rst),
    .pin_rst_n(pin_rst_n), .busy(busy), .cause(cause));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: phase 0 idle, 1 handshake, 2 reset hold, 3 release, 4 cold
  int m_ph = 4, m_i = 0, m_t = 0, m_c = 0;
  logic [31:0] m_cause = 0;
  logic [6:0]  m_prev = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 4; m_i = 0; m_t = 0; m_c = 0; m_cause = 0; m_prev = 0;
    end else begin
      logic [31:0] ev;
      bit adv;
      int lim;
      ev = 0;
      for (int b = 0; b < 5; b++) ev[b] = cold_req[b];
      for (int b = 0; b < 3; b++) ev[8 + b] = warm_req[b];
      for (int b = 0; b < 4; b++) ev[12 + b] = warm_req[3 + b];
      ev[18] = dbg_req[0];
      ev[19] = dbg_req[1];
      adv = 0;
      if (m_ph == 1) begin
        if (!cfg_hs_en[m_i] || hs_ack[m_i]) adv = 1;
        else if (m_t == TMO - 1) begin adv = 1; ev[24 + m_i] = 1; end
      end
      m_cause = (m_cause & ~(clr_we ? clr_mask : 32'h0)) | ev;
      if (cold_req != 0) begin
        m_ph = 4; m_c = 0;
      end else begin
        case (m_ph)
          0: if ((warm_req & ~m_prev) != 0) begin m_ph = 1; m_i = 0; m_t = 0; end
          1: if (adv) begin
               m_t = 0;
               if (m_i == 4) begin m_ph = 2; m_c = 0; end else m_i++;
             end else m_t++;
          2: if (m_c + 1 >= int'(cfg_pin_len)) begin m_ph = 3; m_c = 0; end else m_c++;
          3: begin
               lim = (cfg_rel_dly < 17) ? 17 : int'(cfg_rel_dly);
               if (m_c + 1 >= lim) m_ph = 0; else m_c++;
             end
          default: begin m_ph = 3; m_c = 0; end
        endcase
      end
      m_prev = warm_req;
    end
  end

  // partner responder, per-cycle comparison and counters
  always @(negedge clk) begin
    logic [4:0] ereq;
    for (int i = 0; i < 5; i++) begin
      if (hs_req[i]) begin wc[i]++; hs_ack[i] = ack_ok[i] && wc[i] >= 3; end
      else begin wc[i] = 0; hs_ack[i] = 0; end
    end
    ereq = (m_ph == 1 && cfg_hs_en[m_i]) ? 5'(1 << m_i) : 5'b0;
    chk("R5 hs_req", {27'b0, hs_req}, {27'b0, ereq});
    chk("R8 clk_rst", {31'b0, clk_rst}, {31'b0, (m_ph == 2 || m_ph == 4)});
    chk("R8 sys_rst", {31'b0, sys_rst}, {31'b0, (m_ph >= 2)});
    chk("R7 pin_rst_n", {31'b0, pin_rst_n},
        {31'b0, !((m_ph == 2 && cfg_pin_len != 0) || m_ph == 4)});
    chk("R11 busy", {31'b0, busy}, {31'b0, (m_ph != 0)});
    chk("R2 cause", cause, m_cause);
    if (rst_n) begin
      if (!pin_rst_n) n_pin++;
      if (sys_rst && !clk_rst) n_rel++;
      if (hs_req[0]) n_req0++;
      if (hs_req != 0 && hs_req != last_req)
        for (int i = 0; i < 5; i++) if (hs_req[i]) order_q.push_back(i);
      last_req = hs_req;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  task automatic wait_idle();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic pulse_warm(input int b);
    @(negedge clk) warm_req[b] = 1;
    @(negedge clk) warm_req[b] = 0;
  endtask

  task automatic clear_all();
    @(negedge clk) begin clr_we = 1; clr_mask = 32'hFFFF_FFFF; end
    @(negedge clk) begin clr_we = 0; clr_mask = 0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 clk_rst in reset", {31'b0, clk_rst}, 1);
    chk("R1 sys_rst in reset", {31'b0, sys_rst}, 1);
    chk("R1 pin in reset", {31'b0, pin_rst_n}, 0);
    chk("R1 hs_req in reset", {27'b0, hs_req}, 0);
    chk("R1 cause in reset", cause, 0);
    rst_n = 1;
    wait_idle();
    chk("R1 idle after reset", {31'b0, busy}, 0);

    // full sequence, all partners acknowledge
    n_pin = 0; n_rel = 0; order_q.delete();
    pulse_warm(2);
    wait_idle();
    chk("R2 software warm bit10", {31'b0, cause[10]}, 1);
    chk("R5 order", order_q.size() == 5 && order_q[0] == 0 && order_q[4] == 4 ? 1 : 0, 1);
    chk("R7 pin length", n_pin, 5);
    chk("R8 release delay", n_rel, 20);

    // sparse enables, timeouts on partners 0 and 4, pin disabled, delay clamp
    clear_all();
    cfg_hs_en = 5'b10101; ack_ok = 5'b00100; cfg_pin_len = 0; cfg_rel_dly = 3;
    n_pin = 0; n_rel = 0; n_req0 = 0; order_q.delete();
    pulse_warm(0);
    wait_idle();
    chk("R3 sdram timeout bit24", {31'b0, cause[24]}, 1);
    chk("R3 trace timeout bit28", {31'b0, cause[28]}, 1);
    chk("R3 acked partner bit26", {31'b0, cause[26]}, 0);
    chk("R5 skipped partners", order_q.size(), 3);
    chk("R6 timeout length", n_req0, TMO);
    chk("R7 zero pin length", n_pin, 0);
    chk("R8 clamped delay", n_rel, 17);

    // watchdog edge during a sequence: logged, no restart
    clear_all();
    cfg_hs_en = 5'b11111; ack_ok = 5'b11111; cfg_pin_len = 4; cfg_rel_dly = 18;
    pulse_warm(1);
    repeat (3) @(negedge clk);
    pulse_warm(3);
    wait_idle();
    repeat (5) @(negedge clk);
    chk("R9 no restart", {31'b0, busy}, 0);
    chk("R9 watchdog logged bit12", {31'b0, cause[12]}, 1);

    // cold source during a pending handshake
    clear_all();
    ack_ok = 5'b00000;
    pulse_warm(2);
    repeat (3) @(negedge clk);
    cold_req[2] = 1;
    @(negedge clk);
    chk("R10 cold asserts sys_rst", {31'b0, sys_rst}, 1);
    chk("R10 cold drops request", {27'b0, hs_req}, 0);
    chk("R10 cold drives pin", {31'b0, pin_rst_n}, 0);
    @(negedge clk) cold_req[2] = 0;
    @(negedge clk);
    chk("R10 release after cold", {30'b0, clk_rst, sys_rst}, 1);
    wait_idle();
    chk("R10 cold logged bit2", {31'b0, cause[2]}, 1);
    ack_ok = 5'b11111;

    // debug sources logged only; clear vs active set
    dbg_req = 2'b11;
    repeat (3) @(negedge clk);
    chk("R2 debug no sequence", {31'b0, busy}, 0);
    clr_we = 1; clr_mask = 32'hFFFF_FFFF;
    @(negedge clk);
    clr_we = 0; clr_mask = 0;
    chk("R4 set wins over clear", cause, 32'h000C_0000);
    dbg_req = 0;
    @(negedge clk) begin clr_we = 1; clr_mask = 32'h0004_0000; end
    @(negedge clk) begin clr_we = 0; clr_mask = 0; end
    chk("R4 masked clear", cause, 32'h0008_0000);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule